// File: doc/BRIEF.md
# PTP Packet Identity Extractor

This block watches a received Ethernet frame byte by byte and pulls out the three values that identify a precision-time-protocol event message: its 4-bit message type, its 16-bit sequence number and a 12-bit hash over ten header bytes. It works out from the EtherType where the time-protocol header starts. The header may sit directly after the Ethernet header, or behind an IPv4 header of variable length plus UDP, or behind a fixed IPv6 header plus UDP. A single 802.1Q tag may come before the EtherType. The block recognises both header versions: in version 2 the message type is in the first header byte, and in version 1 it is in a later control byte.

One cycle after the last byte of a frame, the block gives a result pulse. The pulse carries the extracted fields, a flag for a recognised encapsulation, a flag for a frame that ends too early, a flag for a sync message, and a match flag. The match flag compares the fields against an identity held on a compare port. Hardware that keeps timestamp records can use the match flag to pair a captured timestamp with the frame it belongs to.

Top module: `ptpid_extractor`

## Requirements
- R1: EtherType 0x88F7 (bytes 12..13) places the header immediately after the 14-byte Ethernet header.
- R2: EtherType 0x0800 places the header after the IPv4 header, whose length is 4 times the low nibble of its first byte, plus 8 UDP bytes.
- R3: EtherType 0x86DD places the header after a fixed 40-byte IPv6 header plus 8 UDP bytes.
- R4: EtherType 0x8100 marks a 4-byte tag. The real EtherType is then read at bytes 16..17, and every later offset moves by 4.
- R5: The header version is the low nibble of header byte 1. The value 1 selects the low nibble of header byte 32 as the message type. Any other value selects the low nibble of header byte 0.
- R6: The sequence number is header bytes 30 (high) and 31 (low).
- R7: The hash is bits 31..20 of a CRC over header bytes 20..29. The CRC uses polynomial 0x04C11DB7, starts at all ones, shifts left, takes the data bits of each byte LSB first, and is not inverted.
- R8: The sync flag is set only for a complete frame whose message type is 0.
- R9: A recognised frame is short when it ends before header byte 31 (version 2) or before header byte 32 (version 1). A short frame reports short=1, sync=0 and match=0.
- R10: The match flag is set only for a complete frame whose message type, sequence number and hash all equal the compare port values, which are sampled with the last byte.
- R11: The result outputs change and res_valid pulses for exactly one cycle, in the cycle after the last byte is accepted.
- R12: A frame whose EtherType is none of the above, or which ends before its encapsulation is decided, reports found=0, short=0, sync=0 and match=0.
- R13: Cycles with in_valid low are ignored, whatever is on in_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_data holds a frame byte |
| in_data | input | 8 | Frame byte, in wire order |
| in_last | input | 1 | Current byte is the last of the frame |
| cmp_msgtype | input | 4 | Message type to compare against |
| cmp_seqid | input | 16 | Sequence number to compare against |
| cmp_hash | input | 12 | Hash to compare against |
| res_valid | output | 1 | One-cycle result pulse |
| res_found | output | 1 | Encapsulation recognised |
| res_short | output | 1 | Recognised, but the frame ended too early |
| res_msgtype | output | 4 | Extracted message type |
| res_seqid | output | 16 | Extracted sequence number |
| res_hash | output | 12 | Extracted 12-bit hash |
| res_sync | output | 1 | Complete sync message |
| res_match | output | 1 | Identity equals the compare port |

## Verification
The hardest case to reach is a frame cut off exactly at a decision boundary. Examples are a frame that ends on the last EtherType byte, on the IPv4 length byte, or one byte before the sequence number or the version 1 control byte. In these cases the encapsulation decision and the final field capture fall on the same edge as the end of the frame. The bench gets there by building full frames for a tagged IPv4 version 1 case, an untagged layer-2 version 2 case and an IPv6 case, then replaying each one truncated at every length through the region of interest. A sweep over encapsulation, tagging, version, message type and compare variants, with idle gaps inserted, covers the main paths.

// File: rtl/ptpid_pkg.sv
package ptpid_pkg;
  localparam int MT_W   = 4;
  localparam int SEQ_W  = 16;
  localparam int HASH_W = 12;
  localparam int CRC_W  = 32;

  localparam int ETH_HDR  = 14;
  localparam int VLAN_LEN = 4;
  localparam int IP6_LEN  = 40;
  localparam int UDP_LEN  = 8;

  localparam logic [15:0] ET_VLAN = 16'h8100;
  localparam logic [15:0] ET_PTP  = 16'h88F7;
  localparam logic [15:0] ET_IP4  = 16'h0800;
  localparam logic [15:0] ET_IP6  = 16'h86DD;

  localparam int HASH_START = 20;
  localparam int HASH_BYTES = 10;
  localparam int SEQ_OFF    = 30;
  localparam int CTL_OFF    = 32;

  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  // one byte of the left-shifting CRC, data bits taken LSB first
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[CRC_W-1] ^ b[k]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                   r = {r[CRC_W-2:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/ptpid_hdr_locator.sv
module ptpid_hdr_locator
  import ptpid_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] off,
  output logic             known_q,
  output logic             known_nxt
);
  localparam logic [POS_W-1:0] POS_MAX   = '1;
  localparam logic [POS_W-1:0] BASE_PLN  = POS_W'(ETH_HDR);
  localparam logic [POS_W-1:0] BASE_TAG  = POS_W'(ETH_HDR + VLAN_LEN);
  localparam logic [POS_W-1:0] L4_SKIP6  = POS_W'(IP6_LEN + UDP_LEN);
  localparam logic [POS_W-1:0] UDP_SKIP  = POS_W'(UDP_LEN);

  logic [POS_W-1:0] pos_q, pos_d, off_q, off_d;
  logic [7:0]       et_hi_q, et_hi_d;
  logic             vlan_q, vlan_d, v4_q, v4_d, known_d;
  logic [POS_W-1:0] base;
  logic [15:0]      etype;

  always_comb begin
    pos_d   = pos_q;
    off_d   = off_q;
    et_hi_d = et_hi_q;
    vlan_d  = vlan_q;
    v4_d    = v4_q;
    known_d = known_q;
    base    = vlan_q ? BASE_TAG : BASE_PLN;
    etype   = {et_hi_q, in_data};
    if (in_valid) begin
      if (pos_q != POS_MAX) pos_d = pos_q + 1'b1;
      if (pos_q == base - POS_W'(2)) et_hi_d = in_data;
      if (!known_q) begin
        if (pos_q == base - POS_W'(1)) begin
          if (etype == ET_VLAN && !vlan_q) begin
            vlan_d = 1'b1;
          end else if (etype == ET_PTP) begin
            known_d = 1'b1;
            off_d   = pos_q + POS_W'(1);
          end else if (etype == ET_IP6) begin
            known_d = 1'b1;
            off_d   = pos_q + POS_W'(1) + L4_SKIP6;
          end else if (etype == ET_IP4) begin
            v4_d = 1'b1;
          end
        end else if (v4_q && pos_q == base) begin
          known_d = 1'b1;
          v4_d    = 1'b0;
          off_d   = base + POS_W'({in_data[3:0], 2'b00}) + UDP_SKIP;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || (in_valid && in_last)) begin
      pos_q   <= '0;
      off_q   <= '0;
      et_hi_q <= '0;
      vlan_q  <= 1'b0;
      v4_q    <= 1'b0;
      known_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      off_q   <= off_d;
      et_hi_q <= et_hi_d;
      vlan_q  <= vlan_d;
      v4_q    <= v4_d;
      known_q <= known_d;
    end
  end

  assign pos       = pos_q;
  assign off       = off_q;
  assign known_nxt = known_d;
endmodule

// File: rtl/ptpid_crc_hash.sv
module ptpid_crc_hash
  import ptpid_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              en,
  input  logic [7:0]        data,
  output logic [HASH_W-1:0] hash_nxt
);
  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = en ? crc_step(crc_q, data) : crc_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= CRC_INIT;
    else              crc_q <= crc_d;
  end

  assign hash_nxt = crc_d[CRC_W-1 -: HASH_W];
endmodule

// File: rtl/ptpid_field_capture.sv
module ptpid_field_capture
  import ptpid_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  off,
  input  logic              known_q,
  input  logic              known_nxt,
  input  logic [HASH_W-1:0] hash_nxt,
  input  logic [MT_W-1:0]   cmp_msgtype,
  input  logic [SEQ_W-1:0]  cmp_seqid,
  input  logic [HASH_W-1:0] cmp_hash,
  output logic              crc_en,
  output logic              res_valid,
  output logic              res_found,
  output logic              res_short,
  output logic [MT_W-1:0]   res_msgtype,
  output logic [SEQ_W-1:0]  res_seqid,
  output logic [HASH_W-1:0] res_hash,
  output logic              res_sync,
  output logic              res_match
);
  localparam logic [POS_W-1:0] R_MT  = POS_W'(0);
  localparam logic [POS_W-1:0] R_VER = POS_W'(1);
  localparam logic [POS_W-1:0] R_H0  = POS_W'(HASH_START);
  localparam logic [POS_W-1:0] R_H1  = POS_W'(HASH_START + HASH_BYTES - 1);
  localparam logic [POS_W-1:0] R_SQH = POS_W'(SEQ_OFF);
  localparam logic [POS_W-1:0] R_SQL = POS_W'(SEQ_OFF + 1);
  localparam logic [POS_W-1:0] R_CTL = POS_W'(CTL_OFF);

  logic             hit, frame_end;
  logic [POS_W-1:0] rel;
  logic [MT_W-1:0]  mt_q, mt_n, ver_q, ver_n, ctl_q, ctl_n, mt_sel;
  logic [SEQ_W-1:0] seq_q, seq_n;
  logic             gs_q, gs_n, gc_q, gc_n;
  logic             is_v1, complete, ok, id_eq;

  assign hit       = in_valid && known_q && (pos >= off);
  assign rel       = pos - off;
  assign frame_end = in_valid && in_last;
  assign crc_en    = hit && (rel >= R_H0) && (rel <= R_H1);

  always_comb begin
    mt_n  = mt_q;
    ver_n = ver_q;
    ctl_n = ctl_q;
    seq_n = seq_q;
    gs_n  = gs_q;
    gc_n  = gc_q;
    if (hit) begin
      if (rel == R_MT)  mt_n  = in_data[MT_W-1:0];
      if (rel == R_VER) ver_n = in_data[MT_W-1:0];
      if (rel == R_SQH) seq_n[SEQ_W-1:8] = in_data;
      if (rel == R_SQL) begin
        seq_n[7:0] = in_data;
        gs_n       = 1'b1;
      end
      if (rel == R_CTL) begin
        ctl_n = in_data[MT_W-1:0];
        gc_n  = 1'b1;
      end
    end
  end

  assign is_v1    = (ver_n == MT_W'(1));
  assign mt_sel   = is_v1 ? ctl_n : mt_n;
  assign complete = is_v1 ? gc_n : gs_n;
  assign ok       = known_nxt && complete;
  assign id_eq    = (mt_sel == cmp_msgtype) && (seq_n == cmp_seqid) &&
                    (hash_nxt == cmp_hash);

  always_ff @(posedge clk) begin
    if (rst) begin
      mt_q <= '0; ver_q <= '0; ctl_q <= '0; seq_q <= '0;
      gs_q <= 1'b0; gc_q <= 1'b0;
      res_valid   <= 1'b0;
      res_found   <= 1'b0;
      res_short   <= 1'b0;
      res_msgtype <= '0;
      res_seqid   <= '0;
      res_hash    <= '0;
      res_sync    <= 1'b0;
      res_match   <= 1'b0;
    end else begin
      res_valid <= frame_end;
      if (frame_end) begin
        mt_q <= '0; ver_q <= '0; ctl_q <= '0; seq_q <= '0;
        gs_q <= 1'b0; gc_q <= 1'b0;
        res_found   <= known_nxt;
        res_short   <= known_nxt && !complete;
        res_msgtype <= mt_sel;
        res_seqid   <= seq_n;
        res_hash    <= hash_nxt;
        res_sync    <= ok && (mt_sel == '0);
        res_match   <= ok && id_eq;
      end else begin
        mt_q <= mt_n; ver_q <= ver_n; ctl_q <= ctl_n; seq_q <= seq_n;
        gs_q <= gs_n; gc_q <= gc_n;
      end
    end
  end
endmodule

// File: rtl/ptpid_extractor.sv
module ptpid_extractor
  import ptpid_pkg::*;
#(
  // byte counter width; must count past the deepest header field (tag +
  // longest IPv4 header + UDP + control byte, about 120 bytes)
  parameter int POS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [MT_W-1:0]   cmp_msgtype,
  input  logic [SEQ_W-1:0]  cmp_seqid,
  input  logic [HASH_W-1:0] cmp_hash,
  output logic              res_valid,
  output logic              res_found,
  output logic              res_short,
  output logic [MT_W-1:0]   res_msgtype,
  output logic [SEQ_W-1:0]  res_seqid,
  output logic [HASH_W-1:0] res_hash,
  output logic              res_sync,
  output logic              res_match
);
  logic [POS_W-1:0]  pos, off;
  logic              known_q, known_nxt, crc_en;
  logic [HASH_W-1:0] hash_nxt;

  ptpid_hdr_locator #(.POS_W(POS_W)) u_loc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .pos(pos), .off(off), .known_q(known_q),
    .known_nxt(known_nxt)
  );

  ptpid_crc_hash u_crc (
    .clk(clk), .rst(rst), .clear(in_valid && in_last), .en(crc_en),
    .data(in_data), .hash_nxt(hash_nxt)
  );

  ptpid_field_capture #(.POS_W(POS_W)) u_cap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .pos(pos), .off(off), .known_q(known_q),
    .known_nxt(known_nxt), .hash_nxt(hash_nxt),
    .cmp_msgtype(cmp_msgtype), .cmp_seqid(cmp_seqid), .cmp_hash(cmp_hash),
    .crc_en(crc_en), .res_valid(res_valid), .res_found(res_found),
    .res_short(res_short), .res_msgtype(res_msgtype),
    .res_seqid(res_seqid), .res_hash(res_hash), .res_sync(res_sync),
    .res_match(res_match)
  );
endmodule

// File: rtl/ptpid_extractor_chk.sv
module ptpid_extractor_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_last,
  input logic       res_valid,
  input logic       res_found,
  input logic       res_short,
  input logic [3:0] res_msgtype,
  input logic       res_sync,
  input logic       res_match
);
  // R11
  valid_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> res_valid);

  // R11
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> !res_valid);

  // R10
  match_complete_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_match) |-> (res_found && !res_short));

  // R9
  short_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_short) |-> (!res_sync && !res_match));

  // R8
  sync_zero_type_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_sync) |-> (res_msgtype == 4'd0));

  // R12
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_found) |-> (!res_short && !res_match && !res_sync));
endmodule

bind ptpid_extractor ptpid_extractor_chk u_chk (.*);

// File: tb/tb_ptpid_extractor.sv
`timescale 1ns/1ps
module tb_ptpid_extractor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [3:0]  cmp_msgtype = '0;
  logic [15:0] cmp_seqid = '0;
  logic [11:0] cmp_hash = '0;
  logic        res_valid, res_found, res_short, res_sync, res_match;
  logic [3:0]  res_msgtype;
  logic [15:0] res_seqid;
  logic [11:0] res_hash;

  always #2.5 clk = ~clk;

  ptpid_extractor dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .cmp_msgtype(cmp_msgtype), .cmp_seqid(cmp_seqid),
    .cmp_hash(cmp_hash), .res_valid(res_valid), .res_found(res_found),
    .res_short(res_short), .res_msgtype(res_msgtype),
    .res_seqid(res_seqid), .res_hash(res_hash), .res_sync(res_sync),
    .res_match(res_match)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] fr [0:191];
  int flen;

  // expected values
  bit e_found, e_complete, e_sync, e_match;
  int e_mt, e_seq, e_hash;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int ref_hash(input int s);
    bit [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 8; k++) begin
        bit fb = c[31] ^ fr[s+i][k];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    return int'(c[31:20]);
  endfunction

  // expected result for the first len bytes of fr
  task automatic model(input int len);
    int base = 14;
    int et, off, ver, need;
    e_found = 0; off = 0;
    et = (len >= 14) ? {fr[12], fr[13]} : -1;
    if (et == 16'h8100) et = (len >= 18) ? {fr[16], fr[17]} : -1;
    if (len >= 18 && {fr[12], fr[13]} == 16'h8100) base = 18;
    if (et == 16'h88F7 && len >= base) begin e_found = 1; off = base; end
    if (et == 16'h86DD && len >= base) begin e_found = 1; off = base + 48; end
    if (et == 16'h0800 && len > base) begin
      e_found = 1; off = base + int'(fr[base][3:0]) * 4 + 8;
    end
    ver  = (e_found && len > off + 1) ? int'(fr[off+1][3:0]) : 0;
    need = (ver == 1) ? off + 33 : off + 32;
    e_complete = e_found && (len >= need);
    e_mt   = (ver == 1) ? int'(fr[off+32][3:0]) : int'(fr[off][3:0]);
    e_seq  = {fr[off+30], fr[off+31]};
    e_hash = ref_hash(off + 20);
    e_sync = e_complete && (e_mt == 0);
  endtask

  // enc: 0 unknown, 1 layer 2, 2 UDP/IPv4, 3 UDP/IPv6
  task automatic build(input int enc, input int vlan, input int ihl,
                       input int ver, input int mt, input int seq,
                       input int seed);
    int base, off;
    logic [15:0] et;
    for (int i = 0; i < 192; i++) fr[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    base = vlan ? 18 : 14;
    if (vlan) begin fr[12] = 8'h81; fr[13] = 8'h00; end
    case (enc)
      1: et = 16'h88F7;
      2: et = 16'h0800;
      3: et = 16'h86DD;
      default: et = 16'h1234;
    endcase
    fr[base-2] = et[15:8];
    fr[base-1] = et[7:0];
    off = base;
    if (enc == 2) begin fr[base] = 8'(8'h40 | ihl); off = base + ihl * 4 + 8; end
    if (enc == 3) begin fr[base] = 8'h60; off = base + 48; end
    if (ver == 1) begin
      fr[off] = 8'h00; fr[off+1] = 8'h01; fr[off+32] = 8'(8'h50 | mt);
    end else begin
      fr[off] = 8'(8'hA0 | mt); fr[off+1] = 8'h02;
    end
    fr[off+30] = 8'(seq >> 8);
    fr[off+31] = 8'(seq & 255);
    flen = off + 40;
  endtask

  task automatic send(input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b1; in_data = 8'hFF; // R13 noise
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == len - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic judge(input string ctx);
    chk({ctx, " R11 valid"}, int'(res_valid), 1);
    chk({ctx, " R12 found"}, int'(res_found), int'(e_found));
    chk({ctx, " R9 short"}, int'(res_short), int'(e_found && !e_complete));
    chk({ctx, " R8 sync"}, int'(res_sync), int'(e_sync));
    chk({ctx, " R10 match"}, int'(res_match), int'(e_match));
    if (e_complete) begin
      chk({ctx, " R5 msgtype"}, int'(res_msgtype), e_mt);
      chk({ctx, " R6 seqid"}, int'(res_seqid), e_seq);
      chk({ctx, " R7 hash"}, int'(res_hash), e_hash);
    end
  endtask

  task automatic run_cut(input int len, input int full_mt, input int full_seq,
                         input int full_hash, input string ctx);
    cmp_msgtype = 4'(full_mt); cmp_seqid = 16'(full_seq); cmp_hash = 12'(full_hash);
    model(len);
    e_match = e_complete && (e_mt == full_mt) && (e_seq == full_seq) &&
              (e_hash == full_hash);
    send(len, 1'b0);
    judge(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int mts [3] = '{0, 3, 8};
    repeat (4) @(negedge clk);
    chk("R11 reset valid", int'(res_valid), 0);
    chk("R10 reset match", int'(res_match), 0);
    rst = 1'b0;
    @(negedge clk);

    // full sweep: R1 R2 R3 R4 R5 R6 R7 R8 R10 R12 R13
    for (int enc = 0; enc < 4; enc++)
      for (int vl = 0; vl < 2; vl++)
        for (int ver = 1; ver <= 2; ver++)
          for (int m = 0; m < 3; m++)
            for (int k = 0; k < 4; k++) begin
              int seq = (enc * 4099 + vl * 517 + ver * 77 + m * 911 + k) & 16'hFFFF;
              build(enc, vl, 5 + m, ver, mts[m], seq, enc + vl + m + k);
              model(flen);
              cmp_msgtype = 4'(e_mt  ^ ((k == 3) ? 1 : 0));
              cmp_seqid   = 16'(e_seq ^ ((k == 1) ? 16'h0100 : 0));
              cmp_hash    = 12'(e_hash ^ ((k == 2) ? 12'h800 : 0));
              e_match = e_complete && (k == 0);
              send(flen, k[0]);
              judge($sformatf("sweep enc%0d vlan%0d v%0d mt%0d k%0d", enc, vl, ver, mts[m], k));
              @(negedge clk);
              chk("R11 pulse width", int'(res_valid), 0);
            end

    // truncation: layer 2, version 2
    begin
      int fm, fs, fh;
      build(1, 0, 5, 2, 5, 16'hBEEF, 3);
      model(flen); fm = e_mt; fs = e_seq; fh = e_hash;
      for (int len = 1; len <= 50; len++) run_cut(len, fm, fs, fh, $sformatf("R9 cut L2 len%0d", len));
      // tagged IPv4, version 1, sync
      build(2, 1, 6, 1, 0, 16'h1357, 9);
      model(flen); fm = e_mt; fs = e_seq; fh = e_hash;
      for (int len = 10; len <= 86; len++) run_cut(len, fm, fs, fh, $sformatf("R9 cut v4 len%0d", len));
      // IPv6 around the sequence number
      build(3, 0, 5, 2, 2, 16'h00FF, 4);
      model(flen); fm = e_mt; fs = e_seq; fh = e_hash;
      for (int len = 60; len <= 97; len++) run_cut(len, fm, fs, fh, $sformatf("R9 cut v6 len%0d", len));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule